// File: doc/BRIEF.md
# Flag Pair Picker with Condition Evaluator

This block holds the zero-style flag (Z) and carry-style flag (C) of a small processor core. It serves two jobs. A pick operation loads both flags from one adjacent two-bit group of a data word, and a 4-bit index chooses the group. A condition evaluator turns a 4-bit condition code and the present flags into the execute/skip decision for the current instruction.

The condition code is a truth table over the flag pair. This lets one field express any of the sixteen Boolean functions of Z and C. Examples are "both clear", "flags differ" and "C set regardless of Z".

Ordinary instructions can still update Z or C one at a time through their own write enables. The pick operation writes both flags every time and ignores those enables. Flag updates land at the clock edge, so the instruction that follows sees them.

Top module: `flag_pair_picker`

## Requirements
- R1: While reset is asserted (rst_n low), flag_z and flag_c are 0.
- R2: A pick that fires loads pick_data bit 2k+1 into flag_z and bit 2k into flag_c, where k is pick_index. The new values are visible after the next rising clock edge.
- R3: A firing pick writes both flags whatever the values of wz_en and wc_en. A pick has priority over the ordinary flag writes.
- R4: Index 0 selects data bits 1:0, and index 15 selects the two most significant bits, 31:30. Data 2'b10 with index 0 gives Z=1, C=0.
- R5: exec_ok is combinational and equals bit {flag_z,flag_c} of cond_code. With Z as the high bit of that 2-bit number, code 4'b0000 never executes and code 4'b1111 always executes.
- R6: These named condition codes behave as their names state:
  - ZC==00 is 4'b0001, 01 is 4'b0010, 10 is 4'b0100 and 11 is 4'b1000.
  - C clear (x0) is 4'b0101 and C set (x1) is 4'b1010.
  - Z clear (0x) is 4'b0011 and Z set (1x) is 4'b1100.
  - Either flag set is 4'b1110, flags equal is 4'b1001 and flags differ is 4'b0110.
- R7: A pick whose own condition fails (pick_en high, exec_ok low) leaves both flags unchanged.
- R8: With pick_en low and exec_ok high, wz_en loads alu_z into flag_z and wc_en loads alu_c into flag_c. Each enable acts on its own flag only.
- R9: When exec_ok is low, or when no pick and no write enable is active, both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pick_en | input | 1 | Current instruction is a pick |
| pick_data | input | 32 | Data operand (register or immediate) |
| pick_index | input | 4 | Pair index (register or immediate, low 4 bits) |
| cond_code | input | 4 | Condition truth table over {Z,C} |
| wz_en | input | 1 | Ordinary write enable for Z |
| wc_en | input | 1 | Ordinary write enable for C |
| alu_z | input | 1 | Z result of an ordinary instruction |
| alu_c | input | 1 | C result of an ordinary instruction |
| flag_z | output | 1 | Z flag |
| flag_c | output | 1 | C flag |
| exec_ok | output | 1 | Current instruction executes |

## Verification
Picks are tried with walking-pair data so that a wrong index scale or a swapped Z/C shows up. They are also tried at indices 0 and 15, and with every write-enable combination, which separates pick priority from the ordinary writes. Every named condition is applied under all four flag states, which exposes a mis-ordered truth-table bit. A long random stream mixes picks, blocked picks and single-flag writes, and a reference model is compared against the design on every clock.

// File: rtl/flag_pair_picker.sv
module flag_pair_picker #(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pick_en,
  input  logic [DATA_W-1:0]             pick_data,
  input  logic [$clog2(DATA_W/2)-1:0]   pick_index,
  input  logic [3:0]                    cond_code,
  input  logic                          wz_en,
  input  logic                          wc_en,
  input  logic                          alu_z,
  input  logic                          alu_c,
  output logic                          flag_z,
  output logic                          flag_c,
  output logic                          exec_ok
);
  localparam int PAIRS = DATA_W / 2;

  logic [1:0] pair [PAIRS];
  logic [1:0] sel;
  logic       pick_fire;

  genvar g;
  generate
    for (g = 0; g < PAIRS; g++) begin : g_pair
      assign pair[g] = pick_data[2*g+1 : 2*g];
    end
  endgenerate

  assign sel       = pair[pick_index];
  assign exec_ok   = cond_code[{flag_z, flag_c}];
  assign pick_fire = pick_en & exec_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (pick_fire) begin
      flag_z <= sel[1];
      flag_c <= sel[0];
    end else if (exec_ok && !pick_en) begin
      if (wz_en) flag_z <= alu_z;
      if (wc_en) flag_c <= alu_c;
    end
  end

  // R2 R3 R4: a fired pick lands the chosen data bits in Z and C
  a_r2_pick_loads: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en && exec_ok |=> flag_z == $past(pick_data[{pick_index, 1'b1}])
                        && flag_c == $past(pick_data[{pick_index, 1'b0}]));

  // R7: a pick whose condition fails changes nothing
  a_r7_blocked_pick: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en && !exec_ok |=> $stable(flag_z) && $stable(flag_c));

  // R9: with no enabled write, Z holds
  a_r9_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_ok && (pick_en || wz_en)) |=> $stable(flag_z));

  // R9: with no enabled write, C holds
  a_r9_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_ok && (pick_en || wc_en)) |=> $stable(flag_c));

  // R8: an ordinary write to C only leaves Z alone
  a_r8_c_only: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ok && !pick_en && wc_en && !wz_en |=> $stable(flag_z) && flag_c == $past(alu_c));

  // R5: never and always codes
  always_comb begin
    if (rst_n && cond_code == 4'b0000) a_r5_never: assert (!exec_ok);
    if (rst_n && cond_code == 4'b1111) a_r5_always: assert (exec_ok);
  end
endmodule

// File: tb/flag_pair_picker_test.sv
module flag_pair_picker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pick_en = 1'b0;
  logic [31:0] pick_data = '0;
  logic [3:0]  pick_index = '0;
  logic [3:0]  cond_code = 4'b1111;
  logic        wz_en = 1'b0, wc_en = 1'b0, alu_z = 1'b0, alu_c = 1'b0;
  logic        flag_z, flag_c, exec_ok;

  int compared = 0;
  int mismatched = 0;
  int mz = 0, mc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flag_pair_picker uut (
    .clk(clk), .rst_n(rst_n), .pick_en(pick_en), .pick_data(pick_data),
    .pick_index(pick_index), .cond_code(cond_code), .wz_en(wz_en), .wc_en(wc_en),
    .alu_z(alu_z), .alu_c(alu_c), .flag_z(flag_z), .flag_c(flag_c), .exec_ok(exec_ok)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_exec(input logic [3:0] cc);
    int row;
    row = mz * 2 + mc;
    return (cc >> row) & 1;
  endfunction

  // called at negedge with inputs already driven
  task automatic step(input string tag);
    int ex;
    #1;
    ex = model_exec(cond_code);
    cmp({tag, " R5 exec"}, exec_ok, ex);
    @(posedge clk);
    if (pick_en && ex == 1) begin
      mz = pick_data[2*pick_index+1];
      mc = pick_data[2*pick_index];
    end else if (!pick_en && ex == 1) begin
      if (wz_en) mz = alu_z;
      if (wc_en) mc = alu_c;
    end
    @(negedge clk);
    #1;
    cmp({tag, " Z"}, flag_z, mz);
    cmp({tag, " C"}, flag_c, mc);
  endtask

  task automatic drive(input logic pe, input logic [31:0] d, input logic [3:0] ix,
                       input logic [3:0] cc, input logic wz, input logic wc,
                       input logic az, input logic ac);
    pick_en = pe; pick_data = d; pick_index = ix; cond_code = cc;
    wz_en = wz; wc_en = wc; alu_z = az; alu_c = ac;
  endtask

  task automatic set_flags(input int z, input int c);
    drive(1, {30'd0, z[0], c[0]}, 0, 4'b1111, 0, 0, 0, 0);
    step("setup R2");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    #1;
    cmp("R1 reset Z", flag_z, 0);
    cmp("R1 reset C", flag_c, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: data 2'b10 index 0 -> Z=1 C=0
    drive(1, 32'h0000_0002, 0, 4'b1111, 0, 0, 0, 0); step("R4 idx0");
    cmp("R4 idx0 Z", flag_z, 1);
    cmp("R4 idx0 C", flag_c, 0);
    // R4: index 15 picks msbs
    drive(1, 32'h4000_0003, 15, 4'b1111, 0, 0, 0, 0); step("R4 idx15");
    cmp("R4 idx15 Z", flag_z, 0);
    cmp("R4 idx15 C", flag_c, 1);

    // R2: walking pair patterns over every index
    for (int k = 0; k < 16; k++) begin
      drive(1, 32'h1 << (2*k+1), k[3:0], 4'b1111, 0, 0, 0, 0); step("R2 walk hi");
      drive(1, ~(32'h1 << (2*k+1)), k[3:0], 4'b1111, 0, 0, 0, 0); step("R2 walk lo");
    end

    // R3: enables have no effect on pick
    for (int e = 0; e < 4; e++) begin
      drive(1, 32'h0000_0030, 2, 4'b1111, e[1], e[0], 0, 1); step("R3 enables");
      cmp("R3 pick Z", flag_z, 1);
      cmp("R3 pick C", flag_c, 1);
    end

    // R7: blocked pick (never code)
    set_flags(0, 1);
    drive(1, 32'hFFFF_FFFF, 5, 4'b0000, 1, 1, 1, 0); step("R7 blocked");
    cmp("R7 Z kept", flag_z, 0);
    cmp("R7 C kept", flag_c, 1);

    // R8: single-flag writes
    set_flags(0, 0);
    drive(0, 0, 0, 4'b1111, 1, 0, 1, 1); step("R8 wz only");
    cmp("R8 Z set", flag_z, 1);
    cmp("R8 C untouched", flag_c, 0);
    drive(0, 0, 0, 4'b1111, 0, 1, 0, 1); step("R8 wc only");
    cmp("R8 Z untouched", flag_z, 1);
    cmp("R8 C set", flag_c, 1);

    // R9: hold when condition fails or nothing enabled
    drive(0, 0, 0, 4'b0001, 1, 1, 0, 0); step("R9 cond fail");
    cmp("R9 Z held", flag_z, 1);
    drive(0, 0, 0, 4'b1111, 0, 0, 0, 0); step("R9 idle");
    cmp("R9 C held", flag_c, 1);

    // R6: named conditions under every flag state
    for (int s = 0; s < 4; s++) begin
      int z, c;
      z = s >> 1; c = s & 1;
      set_flags(z, c);
      cond_code = 4'b0001; #1; cmp("R6 00", exec_ok, (z == 0 && c == 0));
      cond_code = 4'b0010; #1; cmp("R6 01", exec_ok, (z == 0 && c == 1));
      cond_code = 4'b0100; #1; cmp("R6 10", exec_ok, (z == 1 && c == 0));
      cond_code = 4'b1000; #1; cmp("R6 11", exec_ok, (z == 1 && c == 1));
      cond_code = 4'b0101; #1; cmp("R6 x0", exec_ok, (c == 0));
      cond_code = 4'b1010; #1; cmp("R6 x1", exec_ok, (c == 1));
      cond_code = 4'b0011; #1; cmp("R6 0x", exec_ok, (z == 0));
      cond_code = 4'b1100; #1; cmp("R6 1x", exec_ok, (z == 1));
      cond_code = 4'b1110; #1; cmp("R6 either", exec_ok, (z == 1 || c == 1));
      cond_code = 4'b1001; #1; cmp("R6 same", exec_ok, (z == c));
      cond_code = 4'b0110; #1; cmp("R6 diff", exec_ok, (z != c));
      cond_code = 4'b0000; #1; cmp("R5 never", exec_ok, 0);
      cond_code = 4'b1111; #1; cmp("R5 always", exec_ok, 1);
      @(negedge clk);
    end

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], $urandom, r[4:1], r[8:5], r[9], r[10], r[11], r[12]);
      step("R2 R7 R8 random");
    end

    // R1: reset in mid-run
    set_flags(1, 1);
    rst_n = 1'b0; #1;
    cmp("R1 async Z", flag_z, 0);
    cmp("R1 async C", flag_c, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule